// File: doc/BRIEF.md
# Unaligned DMA Address Sequencer

This block produces the address, access size and byte-lane strobe for one DMA channel that moves a byte buffer over a 32-bit system bus. Software sets a start address and a byte count while the channel is idle. A second load path, standing in for a descriptor fetch, can set both values in one cycle. A start pulse then arms the channel. From that point the block presents one address phase after another and moves the address forward by the width of each accepted access.

A buffer may begin and end on any byte. At such boundaries the sequencer picks narrower accesses, so that no lane outside the buffer is ever strobed. The channel stops when the byte count is used up. It can also stop early: if the early-stop option is enabled, an external end-of-transfer event ends the channel once the access currently in its address phase has been accepted. Only address-phase handshakes are modelled. Data movement, bursts, wait states and error responses belong to other blocks.

Top module: `udma_addr_seq`

## Requirements
- R1: After reset, chan_enb, bus_req and done are 0, and bus_addr and rem_cnt are 0.
- R2: While chan_enb is 0, sw_addr_we loads bus_addr from sw_addr and sw_len_we loads rem_cnt from sw_len. desc_load loads both from desc_addr and desc_len, and it takes priority over the software writes in the same cycle. While chan_enb is 1, all three are ignored and bus_addr and rem_cnt keep their values.
- R3: A start pulse while chan_enb is 0 and rem_cnt is nonzero sets chan_enb in the next cycle. A start pulse with rem_cnt equal to 0 leaves chan_enb at 0 and raises done for exactly one cycle.
- R4: bus_size encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. The width is 1 byte when bus_addr[0] is 1 or rem_cnt is 1. Otherwise it is 2 bytes when bus_addr[1] is 1 or rem_cnt is below 4. Otherwise it is 4 bytes. An access never exceeds rem_cnt.
- R5: bus_strb bit i (lane i, with bit 0 the byte at word offset 0) is 1 exactly for the lanes from bus_addr[1:0] up to bus_addr[1:0] plus the width minus 1.
- R6: bus_addr and rem_cnt change only at an address-phase handshake (bus_req and bus_ready both 1 at a clock edge). At a handshake, bus_addr advances by the access width, modulo 2^ADDR_W, and rem_cnt drops by the same amount. Both hold while bus_ready is 0.
- R7: At a handshake that brings rem_cnt to 0, chan_enb is 0 from the next cycle and done is 1 for exactly that one cycle.
- R8: With eot_en at 1, an eot_in pulse while chan_enb is 1 lets the access in its address phase complete. If bus_ready is 1 in the same cycle, that access is the one handshaken in that cycle. At that handshake the channel stops: chan_enb goes to 0 and done pulses one cycle, and bus_addr and rem_cnt reflect the completed access.
- R9: With eot_en at 0, eot_in has no effect, and the transfer runs until rem_cnt reaches 0.
- R10: bus_req is 1 exactly while chan_enb is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_addr_we | input | 1 | Software write strobe for the address |
| sw_addr | input | ADDR_W | Software start address |
| sw_len_we | input | 1 | Software write strobe for the byte count |
| sw_len | input | CNT_W | Software byte count |
| desc_load | input | 1 | Descriptor-style load of address and count |
| desc_addr | input | ADDR_W | Loaded start address |
| desc_len | input | CNT_W | Loaded byte count |
| start | input | 1 | Arm the channel |
| eot_en | input | 1 | Allow early stop on eot_in |
| eot_in | input | 1 | External end-of-transfer event |
| bus_ready | input | 1 | Address phase accepted this cycle |
| bus_req | output | 1 | Address phase valid |
| bus_addr | output | ADDR_W | Current access address |
| bus_size | output | 2 | Access width code |
| bus_strb | output | 4 | Byte-lane strobe |
| rem_cnt | output | CNT_W | Bytes still to transfer |
| chan_enb | output | 1 | Channel enabled status |
| done | output | 1 | One-cycle end-of-channel pulse |

## Verification
The bench builds the block with ADDR_W of 12 and CNT_W of 6. With a 12-bit address, a buffer that starts at 0xFFD crosses the top of the address space in a few accesses, so the modulo wrap of the address can be seen. Every start offset from 0 to 3 is combined with lengths of 1, 2, 3, 5, 7 and 8, so each narrow-access case at both the head and the tail of a buffer is reached. Early stop is tested in three ways: the event arriving during a stalled address phase, the event arriving in the same cycle as a handshake, and the event arriving with the option disabled.

// File: rtl/udma_seq_pkg.sv
// Shared types for the DMA address sequencer.
// Assumes a 32-bit data bus with four byte lanes.
package udma_seq_pkg;
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;
endpackage

// File: rtl/udma_size_sel.sv
// Access width and lane strobe picker.
// Picks the widest naturally aligned access (1, 2 or 4 bytes) that does not
// run past the remaining count. Assumes CNT_W >= 3. The result is don't-care
// when rem is 0.
module udma_size_sel
    import udma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       addr_lo,
    input  logic [CNT_W-1:0] rem,
    output acc_size_e        size,
    output logic [2:0]       nbytes,
    output logic [LANES-1:0] strb
);
    logic [3:0] lane_end;

    // Width choice from the address offset and the remaining count.
    always_comb begin
        if (addr_lo[0] || rem == CNT_W'(1))
            size = SZ_BYTE;
        else if (addr_lo[1] || rem < CNT_W'(4))
            size = SZ_HALF;
        else
            size = SZ_WORD;
        nbytes   = 3'd1 << size;
        lane_end = {2'b00, addr_lo} + {1'b0, nbytes};
    end

    // One comparator per lane marks the lanes covered by the access.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strb[i] = (4'(i) >= {2'b00, addr_lo}) && (4'(i) < lane_end);
    end
endmodule

// File: rtl/udma_addr_reg.sv
// Address register and remaining-byte counter.
// Loads are accepted only while wr_allow is high. Both values step at each
// address-phase handshake. The address wraps modulo 2^ADDR_W.
module udma_addr_reg #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_allow,
    input  logic              sw_addr_we,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic              sw_len_we,
    input  logic [CNT_W-1:0]  sw_len,
    input  logic              desc_load,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [CNT_W-1:0]  desc_len,
    input  logic              step,
    input  logic [2:0]        nbytes,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  rem
);
    // Address register: load when idle, advance at each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (wr_allow && desc_load)
            addr <= desc_addr;
        else if (wr_allow && sw_addr_we)
            addr <= sw_addr;
        else if (step)
            addr <= addr + ADDR_W'(nbytes);
    end

    // Remaining counter: load when idle, count down at each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (wr_allow && desc_load)
            rem <= desc_len;
        else if (wr_allow && sw_len_we)
            rem <= sw_len;
        else if (step)
            rem <= rem - CNT_W'(nbytes);
    end

    // R6: a handshake moves the address and the count by the same width.
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step && !wr_allow |=> (addr == $past(addr) + ADDR_W'($past(nbytes)))
                           && (rem == $past(rem) - CNT_W'($past(nbytes))));

    // R2: while locked and not stepping, loads cannot disturb the values.
    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow && !step |=> $stable(addr) && $stable(rem));
endmodule

// File: rtl/udma_term_ctrl.sv
// Channel enable and termination control.
// Sets the enable on start when the count is nonzero. Clears it at the
// handshake that uses up the count, or at the first handshake after a
// qualified end-of-transfer event. A single-cycle done marks every stop.
module udma_term_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic eot_en,
    input  logic eot_in,
    input  logic hs,
    input  logic last,
    input  logic rem_zero,
    output logic chan_enb,
    output logic done
);
    logic eot_pend;
    logic eot_hit;
    logic stop;

    // Stop decision for the handshake in this cycle.
    always_comb begin
        eot_hit = eot_pend || (eot_en && eot_in);
        stop    = hs && (last || eot_hit);
    end

    // Enable, pending-event and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_enb <= 1'b0;
            eot_pend <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!chan_enb) begin
                eot_pend <= 1'b0;
                if (start) begin
                    if (rem_zero)
                        done <= 1'b1;
                    else
                        chan_enb <= 1'b1;
                end
            end else if (stop) begin
                chan_enb <= 1'b0;
                eot_pend <= 1'b0;
                done     <= 1'b1;
            end else if (eot_en && eot_in) begin
                eot_pend <= 1'b1;
            end
        end
    end

    // R3: the channel only turns on as a result of a start pulse.
    assert_enb_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_enb) |-> $past(start));

    // R7: done is raised only once the channel is already off.
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !chan_enb);

    // R8: a held event ends the channel at the next handshake.
    assert_eot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chan_enb && hs && eot_pend |=> !chan_enb && done);
endmodule

// File: rtl/udma_addr_seq.sv
// Top of the unaligned DMA address sequencer.
// Joins the width picker, the address/count registers and the termination
// control. Assumes address-phase-only handshakes: each cycle with bus_req and
// bus_ready high counts as one accepted access.
module udma_addr_seq
    import udma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_addr_we,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic              sw_len_we,
    input  logic [CNT_W-1:0]  sw_len,
    input  logic              desc_load,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [CNT_W-1:0]  desc_len,
    input  logic              start,
    input  logic              eot_en,
    input  logic              eot_in,
    input  logic              bus_ready,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [3:0]        bus_strb,
    output logic [CNT_W-1:0]  rem_cnt,
    output logic              chan_enb,
    output logic              done
);
    acc_size_e  size;
    logic [2:0] nbytes;
    logic       hs;
    logic       last;

    // Handshake, last-access and request decode.
    always_comb begin
        bus_req  = chan_enb && (rem_cnt != '0);
        hs       = bus_req && bus_ready;
        last     = (rem_cnt == CNT_W'(nbytes));
        bus_size = size;
    end

    udma_size_sel #(.CNT_W(CNT_W)) u_size (
        .addr_lo (bus_addr[1:0]),
        .rem     (rem_cnt),
        .size    (size),
        .nbytes  (nbytes),
        .strb    (bus_strb)
    );

    udma_addr_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_areg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_allow   (!chan_enb),
        .sw_addr_we (sw_addr_we),
        .sw_addr    (sw_addr),
        .sw_len_we  (sw_len_we),
        .sw_len     (sw_len),
        .desc_load  (desc_load),
        .desc_addr  (desc_addr),
        .desc_len   (desc_len),
        .step       (hs),
        .nbytes     (nbytes),
        .addr       (bus_addr),
        .rem        (rem_cnt)
    );

    udma_term_ctrl #(.CNT_W(CNT_W)) u_term (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .eot_en   (eot_en),
        .eot_in   (eot_in),
        .hs       (hs),
        .last     (last),
        .rem_zero (rem_cnt == '0),
        .chan_enb (chan_enb),
        .done     (done)
    );

    // R4: an access never runs past the remaining count.
    assert_no_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> CNT_W'(nbytes) <= rem_cnt);

    // R4: word accesses only at word-aligned addresses.
    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_size == SZ_WORD |-> bus_addr[1:0] == 2'b00);

    // R5: the number of strobed lanes matches the access width.
    assert_strb_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> $countones(bus_strb) == int'(nbytes));

    // R10: a request appears only while the channel is on.
    assert_req_enb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> chan_enb);
endmodule

// File: tb/udma_addr_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for the unaligned DMA address sequencer.
module udma_addr_seq_bench;
    localparam int AW = 12;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_addr_we = 1'b0;
    logic [AW-1:0] sw_addr = '0;
    logic          sw_len_we = 1'b0;
    logic [CW-1:0] sw_len = '0;
    logic          desc_load = 1'b0;
    logic [AW-1:0] desc_addr = '0;
    logic [CW-1:0] desc_len = '0;
    logic          start = 1'b0;
    logic          eot_en = 1'b0;
    logic          eot_in = 1'b0;
    logic          bus_ready = 1'b0;
    logic          bus_req;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [3:0]    bus_strb;
    logic [CW-1:0] rem_cnt;
    logic          chan_enb;
    logic          done;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    udma_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) u_udma_addr_seq (
        .clk(clk), .rst_n(rst_n),
        .sw_addr_we(sw_addr_we), .sw_addr(sw_addr),
        .sw_len_we(sw_len_we), .sw_len(sw_len),
        .desc_load(desc_load), .desc_addr(desc_addr), .desc_len(desc_len),
        .start(start), .eot_en(eot_en), .eot_in(eot_in),
        .bus_ready(bus_ready), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_strb(bus_strb), .rem_cnt(rem_cnt),
        .chan_enb(chan_enb), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: inputs are driven at falling edges, outputs sampled there.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected width from the requirement's rule.
    function automatic int exp_bytes(input int a, input int r);
        if ((a % 2) == 1 || r == 1) return 1;
        if ((a % 4) == 2 || r < 4)  return 2;
        return 4;
    endfunction

    function automatic int exp_code(input int n);
        return (n == 1) ? 0 : (n == 2) ? 1 : 2;
    endfunction

    function automatic int exp_strb(input int a, input int n);
        int s = 0;
        for (int i = 0; i < 4; i++)
            if (i >= (a % 4) && i < (a % 4) + n) s |= (1 << i);
        return s;
    endfunction

    task automatic load_sw(input int a, input int n);
        sw_addr_we = 1'b1; sw_addr = AW'(a);
        sw_len_we  = 1'b1; sw_len  = CW'(n);
        tick();
        sw_addr_we = 1'b0; sw_len_we = 1'b0;
    endtask

    // Arm an already loaded channel and walk it to the end, optionally
    // stalling one cycle before every handshake.
    task automatic run_loaded(input int a0, input int n0, input bit stall);
        int a = a0;
        int r = n0;
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R3 enable set", int'(chan_enb), 1);
        while (r > 0) begin
            int nb = exp_bytes(a, r);
            if (stall) begin
                bus_ready = 1'b0;
                tick();
                chk("R6 hold addr on stall", int'(bus_addr), a);
                chk("R6 hold count on stall", int'(rem_cnt), r);
            end
            chk("R10 request while enabled", int'(bus_req), 1);
            chk("R6 address", int'(bus_addr), a);
            chk("R4 size code", int'(bus_size), exp_code(nb));
            chk("R5 strobe", int'(bus_strb), exp_strb(a, nb));
            bus_ready = 1'b1;
            tick();
            a = (a + nb) % (1 << AW);
            r = r - nb;
        end
        bus_ready = 1'b0;
        chk("R7 enable cleared", int'(chan_enb), 0);
        chk("R7 done pulse", int'(done), 1);
        chk("R10 request dropped", int'(bus_req), 0);
        chk("R6 final address", int'(bus_addr), a);
        tick();
        chk("R7 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R1 chan_enb", int'(chan_enb), 0);
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 bus_addr", int'(bus_addr), 0);
        chk("R1 rem_cnt", int'(rem_cnt), 0);
    endtask

    task automatic t_align_sweep();
        int lens[6] = '{1, 2, 3, 5, 7, 8};
        for (int off = 0; off < 4; off++) begin
            for (int k = 0; k < 6; k++) begin
                load_sw(12'h100 + off, lens[k]);
                run_loaded(12'h100 + off, lens[k], 1'b0);
            end
        end
    endtask

    task automatic t_stall_and_wrap();
        load_sw(12'hFFD, 5);
        run_loaded(12'hFFD, 5, 1'b1);
    endtask

    task automatic t_desc_load();
        desc_load  = 1'b1; desc_addr = 12'h603; desc_len = 6'd2;
        sw_addr_we = 1'b1; sw_addr   = 12'h111;
        sw_len_we  = 1'b1; sw_len    = 6'd9;
        tick();
        desc_load = 1'b0; sw_addr_we = 1'b0; sw_len_we = 1'b0;
        chk("R2 desc priority addr", int'(bus_addr), 12'h603);
        chk("R2 desc priority count", int'(rem_cnt), 2);
        run_loaded(12'h603, 2, 1'b0);
    endtask

    task automatic t_locked_writes();
        load_sw(12'h500, 12);
        start = 1'b1;
        tick();
        start = 1'b0;
        sw_addr_we = 1'b1; sw_addr = 12'h7AA;
        sw_len_we  = 1'b1; sw_len  = 6'd3;
        desc_load  = 1'b1; desc_addr = 12'h0F0; desc_len = 6'd1;
        tick();
        sw_addr_we = 1'b0; sw_len_we = 1'b0; desc_load = 1'b0;
        chk("R2 locked addr", int'(bus_addr), 12'h500);
        chk("R2 locked count", int'(rem_cnt), 12);
        bus_ready = 1'b1;
        tick(); tick(); tick();
        bus_ready = 1'b0;
        chk("R2 locked run end", int'(chan_enb), 0);
        chk("R2 locked final addr", int'(bus_addr), 12'h50C);
        tick();
    endtask

    task automatic t_zero_len();
        load_sw(12'h700, 0);
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R3 zero count no enable", int'(chan_enb), 0);
        chk("R3 zero count done", int'(done), 1);
        chk("R3 zero count no request", int'(bus_req), 0);
        tick();
        chk("R3 zero count done one cycle", int'(done), 0);
    endtask

    task automatic t_eot_stalled();
        eot_en = 1'b1;
        load_sw(12'h200, 20);
        start = 1'b1;
        tick();
        start = 1'b0;
        bus_ready = 1'b1;
        tick();
        bus_ready = 1'b0; eot_in = 1'b1;
        tick();
        eot_in = 1'b0;
        tick();
        chk("R8 still enabled during stall", int'(chan_enb), 1);
        chk("R8 no done during stall", int'(done), 0);
        chk("R8 addr held", int'(bus_addr), 12'h204);
        bus_ready = 1'b1;
        tick();
        bus_ready = 1'b0;
        chk("R8 stopped", int'(chan_enb), 0);
        chk("R8 done", int'(done), 1);
        chk("R8 addr after last access", int'(bus_addr), 12'h208);
        chk("R8 count after last access", int'(rem_cnt), 12);
        tick();
        eot_en = 1'b0;
    endtask

    task automatic t_eot_same_cycle();
        eot_en = 1'b1;
        load_sw(12'h301, 10);
        start = 1'b1;
        tick();
        start = 1'b0;
        bus_ready = 1'b1; eot_in = 1'b1;
        tick();
        bus_ready = 1'b0; eot_in = 1'b0;
        chk("R8 same-cycle stop", int'(chan_enb), 0);
        chk("R8 same-cycle done", int'(done), 1);
        chk("R8 same-cycle addr", int'(bus_addr), 12'h302);
        chk("R8 same-cycle count", int'(rem_cnt), 9);
        tick();
        eot_en = 1'b0;
    endtask

    task automatic t_eot_disabled();
        eot_en = 1'b0;
        load_sw(12'h400, 8);
        start = 1'b1;
        tick();
        start = 1'b0;
        eot_in = 1'b1;
        tick();
        eot_in = 1'b0;
        chk("R9 event ignored", int'(chan_enb), 1);
        chk("R9 no done", int'(done), 0);
        bus_ready = 1'b1;
        tick();
        chk("R9 still running", int'(chan_enb), 1);
        tick();
        bus_ready = 1'b0;
        chk("R9 ran to end", int'(chan_enb), 0);
        chk("R9 final addr", int'(bus_addr), 12'h408);
        tick();
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_align_sweep();
        t_stall_and_wrap();
        t_desc_load();
        t_locked_writes();
        t_zero_len();
        t_eot_stalled();
        t_eot_same_cycle();
        t_eot_disabled();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule